// File: doc/BRIEF.md
# Serial Audio Frame Realigner (I2S / Left-Justified)

This block sits on the bit-clock side of a serial audio link, between a source that speaks one frame alignment and a sink that expects the other. It re-times the word-select line and the serial data line so that a stream in standard I2S alignment comes out left-justified, or the reverse. A static strap picks the direction. The bit clock is forwarded unchanged. The block neither buffers it nor cleans its jitter.

Every delay is a whole number of bit-clock periods, never half a period. Each one-period hop is built from two flops. The first captures on the falling edge and the second republishes on the next rising edge, so each flop sees half a period of setup and half a period of hold. Word-select and data both pass through these hops. The path that needs to lag gets one extra hop, so the output relation between word-select and the MSB is exact in the target format. The polarity of word-select passes through unchanged: low means the left channel. Once one full word-select frame has passed after reset, the outputs carry the converted stream.

Top module: `i2s_lj_realigner`

## Requirements
- R1: With `dir_i2s_to_lj` = 1 (I2S in, left-justified out), `lrck_o` lags `lrck_i` by exactly 2 bit-clock periods and `sdata_o` lags `sdata_i` by exactly 1 period. The MSB of each word therefore appears in the same period in which `lrck_o` changes.
- R2: With `dir_i2s_to_lj` = 0 (left-justified in, I2S out), `lrck_o` lags `lrck_i` by exactly 1 period and `sdata_o` lags `sdata_i` by exactly 2 periods. `lrck_o` therefore changes one period before the MSB.
- R3: Each one-period hop captures on the falling edge of `bclk` and republishes on the next rising edge. `lrck_o` and `sdata_o` change only just after a rising edge, never at a falling edge.
- R4: Word-select polarity is preserved. A word sent while `lrck_i` = 0 (left) is received while `lrck_o` = 0, and a word sent with 1 (right) is received with 1.
- R5: While `rst_n` is low, every delay flop is cleared and `lrck_o` and `sdata_o` are 0, whatever `lrck_i` and `sdata_i` do.
- R6: `bclk_o` equals `bclk` at all times.
- R7: With 32 bit-clock periods per channel slot, MSB-first words of 16 and 24 bits are recovered bit-exactly at the output in both directions. All slot bits after the word are zero.
- R8: `dir_i2s_to_lj` is a static strap. It is changed only while `rst_n` is low, and the new setting governs the whole stream that follows the next reset release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bclk | input | 1 | Serial bit clock; all hops run on it |
| rst_n | input | 1 | Asynchronous active-low reset of all delay flops |
| dir_i2s_to_lj | input | 1 | Direction strap: 1 = I2S to left-justified, 0 = left-justified to I2S |
| lrck_i | input | 1 | Incoming word-select (0 = left channel) |
| sdata_i | input | 1 | Incoming serial data, MSB first |
| bclk_o | output | 1 | Bit clock forwarded unchanged |
| lrck_o | output | 1 | Re-timed word-select |
| sdata_o | output | 1 | Re-timed serial data |

## Verification
The hardest case to reach from the ports is the channel boundary. An off-by-one hop moves the MSB into the previous slot or the LSB out of the window, and quiet audio would hide that. The bench serializes words in the source format and deserializes the outputs under the target format's rules. It uses MSB-only, LSB-only, all-ones and alternating words, so any slip of one period corrupts a known bit. A preamble edge on word-select is timed from drive to output to measure each lag directly. Reset is held while the inputs toggle, then the strap flips before the next release.

// File: rtl/i2s_realign_pkg.sv
package i2s_realign_pkg;

    // Conversion direction carried by the strap pin.
    typedef enum logic {
        DIR_LJ_TO_I2S = 1'b0,
        DIR_I2S_TO_LJ = 1'b1
    } realign_dir_e;

    // Hops on the path that does not lag; the other path gets one more.
    localparam int unsigned SHORT_HOPS_DEFAULT = 1;

endpackage

// File: rtl/bclk_hop_stage.sv
module bclk_hop_stage (
    input  logic bclk,
    input  logic rst_n,
    input  logic d,
    output logic q
);

    // First half-hop: sample in the middle of the high-to-low phase.
    logic fall_q;

    always_ff @(negedge bclk or negedge rst_n) begin
        if (!rst_n) fall_q <= 1'b0;
        else        fall_q <= d;
    end

    // Second half-hop: republish on the following rising edge.
    always_ff @(posedge bclk or negedge rst_n) begin
        if (!rst_n) q <= 1'b0;
        else        q <= fall_q;
    end

    // Warm-up tracker used only by the check below.
    logic [1:0] warm_q;

    always_ff @(posedge bclk or negedge rst_n) begin
        if (!rst_n) warm_q <= 2'b00;
        else        warm_q <= {warm_q[0], 1'b1};
    end

    // R3: the pair of flops amounts to exactly one rising-edge period.
    assert_one_period_hop_R3: assert property (
        @(posedge bclk) disable iff (!rst_n)
        warm_q[1] |-> (q == $past(d))
    );

endmodule

// File: rtl/hop_delay_line.sv
module hop_delay_line #(
    parameter int unsigned HOPS = 2
) (
    input  logic            bclk,
    input  logic            rst_n,
    input  logic            d,
    output logic [HOPS-1:0] taps
);

    logic [HOPS:0] chain;

    assign chain[0] = d;

    for (genvar h = 0; h < HOPS; h++) begin : g_hop
        bclk_hop_stage u_hop (
            .bclk  (bclk),
            .rst_n (rst_n),
            .d     (chain[h]),
            .q     (chain[h+1])
        );
    end

    // taps[k] is the input delayed by k+1 whole periods.
    assign taps = chain[HOPS:1];

endmodule

// File: rtl/i2s_lj_realigner.sv
module i2s_lj_realigner
    import i2s_realign_pkg::*;
#(
    parameter int unsigned SHORT_HOPS = SHORT_HOPS_DEFAULT
) (
    input  logic bclk,
    input  logic rst_n,
    input  logic dir_i2s_to_lj,
    input  logic lrck_i,
    input  logic sdata_i,
    output logic bclk_o,
    output logic lrck_o,
    output logic sdata_o
);

    localparam int unsigned LONG_HOPS = SHORT_HOPS + 1;
    localparam int unsigned SHORT_IX  = SHORT_HOPS - 1;
    localparam int unsigned LONG_IX   = LONG_HOPS - 1;

    realign_dir_e dir_e;
    assign dir_e = realign_dir_e'(dir_i2s_to_lj);

    logic [LONG_HOPS-1:0] lr_taps;
    logic [LONG_HOPS-1:0] sd_taps;

    hop_delay_line #(.HOPS(LONG_HOPS)) u_lr_line (
        .bclk  (bclk),
        .rst_n (rst_n),
        .d     (lrck_i),
        .taps  (lr_taps)
    );

    hop_delay_line #(.HOPS(LONG_HOPS)) u_sd_line (
        .bclk  (bclk),
        .rst_n (rst_n),
        .d     (sdata_i),
        .taps  (sd_taps)
    );

    // The lagging path takes the long tap; the other takes the short one.
    always_comb begin
        unique case (dir_e)
            DIR_I2S_TO_LJ: begin
                lrck_o  = lr_taps[LONG_IX];
                sdata_o = sd_taps[SHORT_IX];
            end
            DIR_LJ_TO_I2S: begin
                lrck_o  = lr_taps[SHORT_IX];
                sdata_o = sd_taps[LONG_IX];
            end
            default: begin
                lrck_o  = 1'b0;
                sdata_o = 1'b0;
            end
        endcase
    end

    assign bclk_o = bclk;

    // Warm-up tracker for the output-relation checks.
    logic [1:0] chk_warm_q;

    always_ff @(posedge bclk or negedge rst_n) begin
        if (!rst_n) chk_warm_q <= 2'b00;
        else        chk_warm_q <= {chk_warm_q[0], 1'b1};
    end

    // R1: in I2S-to-LJ mode word-select trails the data path by one hop.
    assert_lj_lrck_extra_hop_R1: assert property (
        @(posedge bclk) disable iff (!rst_n)
        (chk_warm_q[1] && dir_i2s_to_lj) |-> (lrck_o == $past(lr_taps[SHORT_IX]))
    );

    // R2: in LJ-to-I2S mode the data trails word-select by one hop.
    assert_i2s_data_extra_hop_R2: assert property (
        @(posedge bclk) disable iff (!rst_n)
        (chk_warm_q[1] && !dir_i2s_to_lj) |-> (sdata_o == $past(sd_taps[SHORT_IX]))
    );

    // R5: outputs held low while reset is asserted.
    assert_reset_clears_R5: assert property (
        @(negedge bclk) !rst_n |-> (!lrck_o && !sdata_o)
    );

    // R8: the strap does not move while the block runs.
    assert_strap_static_R8: assert property (
        @(posedge bclk) disable iff (!rst_n)
        $stable(dir_i2s_to_lj)
    );

endmodule

// File: tb/i2s_lj_realigner_tb.sv
`timescale 1ns/1ps
module i2s_lj_realigner_tb;

    logic bclk = 1'b0;
    logic rst_n = 1'b0;
    logic dir_i2s_to_lj = 1'b1;
    logic lrck_i = 1'b0;
    logic sdata_i = 1'b0;
    logic bclk_o, lrck_o, sdata_o;

    i2s_lj_realigner u_dut (
        .bclk          (bclk),
        .rst_n         (rst_n),
        .dir_i2s_to_lj (dir_i2s_to_lj),
        .lrck_i        (lrck_i),
        .sdata_i       (sdata_i),
        .bclk_o        (bclk_o),
        .lrck_o        (lrck_o),
        .sdata_o       (sdata_o)
    );

    always #10 bclk = ~bclk;   // 50 MHz

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit done = 0;

    always @(posedge bclk) cyc <= cyc + 1;

    // Scoreboard: {channel, word}
    logic [32:0] exp_q[$];

    int  cur_w = 16;
    bit  cur_to_lj = 1;
    int  edge_drive_cyc = 0;

    // ---------------- R3 / R6 edge-stability monitor ----------------
    logic pre_lr, pre_sd;
    int   r3_bad = 0;
    int   r6_bad = 0;

    always @(posedge bclk) begin
        #9;
        pre_lr = lrck_o;
        pre_sd = sdata_o;
        if (bclk_o !== bclk) r6_bad++;
    end

    always @(negedge bclk) begin
        #1;
        if (rst_n && ((lrck_o !== pre_lr) || (sdata_o !== pre_sd))) r3_bad++;
        if (bclk_o !== bclk) r6_bad++;
    end

    // ---------------- Output monitor / deserializer ----------------
    bit          armed = 0;
    bit          collecting = 0;
    logic        prev_lr = 0;
    logic        chan = 0;
    int          pos = 0;
    logic [31:0] word = '0;

    always @(negedge bclk) begin
        #5;
        if (!rst_n) begin
            armed = 0;
            collecting = 0;
            prev_lr = 0;
        end else begin
            if (lrck_o !== prev_lr) begin
                if (!armed) begin
                    if (lrck_o) begin
                        armed = 1;
                        checks++;
                        if ((cyc - edge_drive_cyc) != (cur_to_lj ? 2 : 1)) begin
                            errors++;
                            $display("FAIL %s word-select lag: actual %0d expected %0d",
                                     cur_to_lj ? "R1" : "R2",
                                     cyc - edge_drive_cyc, cur_to_lj ? 2 : 1);
                        end
                    end
                end else begin
                    collecting = 1;
                    pos = 0;
                    word = '0;
                    chan = lrck_o;
                end
            end
            if (collecting) begin
                int first;
                first = cur_to_lj ? 0 : 1;
                if (pos >= first && pos < first + cur_w)
                    word = {word[30:0], sdata_o};
                if (pos == first + cur_w - 1) begin
                    collecting = 0;
                    checks++;
                    if (exp_q.size() == 0) begin
                        errors++;
                        $display("FAIL R7 unexpected word: actual %h expected none", word);
                    end else begin
                        logic [32:0] e;
                        e = exp_q.pop_front();
                        if (e[31:0] !== word) begin
                            errors++;
                            $display("FAIL R7 (%s, %0d-bit) word: actual %h expected %h",
                                     cur_to_lj ? "R1" : "R2", cur_w, word, e[31:0]);
                        end
                        checks++;
                        if (e[32] !== chan) begin
                            errors++;
                            $display("FAIL R4 channel: actual %0d expected %0d", chan, e[32]);
                        end
                    end
                end
                pos++;
            end
            prev_lr = lrck_o;
        end
    end

    // ---------------- Driver ----------------
    function automatic logic [31:0] gen_word(int f, int ch, int w);
        logic [31:0] mask;
        logic [31:0] v;
        mask = (32'h1 << w) - 1;
        case (f)
            0: v = (ch == 0) ? mask : ((32'h1 << (w - 1)) | 32'h1);
            1: v = (ch == 0) ? (32'hAAAAAAAA & mask) : (32'h55555555 & mask);
            2: v = (ch == 0) ? (32'h1 << (w - 1)) : 32'h1;
            default: v = ((f * 32'h9E3779B1) ^ (ch * 32'h85EBCA6B) ^ w) & mask;
        endcase
        return v & mask;
    endfunction

    task automatic drive_bit(logic lr, logic sd);
        @(posedge bclk);
        #5;
        lrck_i = lr;
        sdata_i = sd;
    endtask

    task automatic run_config(bit to_lj, int w, int nframes);
        rst_n = 0;
        lrck_i = 0;
        sdata_i = 0;
        repeat (2) @(posedge bclk);
        dir_i2s_to_lj = to_lj;     // R8: strap moves only in reset
        cur_to_lj = to_lj;
        cur_w = w;
        repeat (3) @(posedge bclk);
        @(negedge bclk);
        #3 rst_n = 1;
        repeat (2) @(posedge bclk);
        // preamble: right-channel slot of zeros
        for (int p = 0; p < 32; p++) begin
            drive_bit(1'b1, 1'b0);
            if (p == 0) edge_drive_cyc = cyc;
        end
        for (int f = 0; f < nframes; f++) begin
            for (int ch = 0; ch < 2; ch++) begin
                logic [31:0] wd;
                wd = gen_word(f, ch, w);
                exp_q.push_back({ch[0], wd});
                for (int p = 0; p < 32; p++) begin
                    int k;
                    logic b;
                    k = to_lj ? p - 1 : p;   // source: I2S when to_lj
                    b = (k >= 0 && k < w) ? wd[w - 1 - k] : 1'b0;
                    drive_bit(ch[0], b);
                end
            end
        end
        // postamble: keep right channel, no edge
        for (int p = 0; p < 40; p++) drive_bit(1'b1, 1'b0);
        checks++;
        if (exp_q.size() != 0) begin
            errors++;
            $display("FAIL R7/R8 (dir %0d, %0d-bit) words left: actual %0d expected 0",
                     to_lj, w, exp_q.size());
            exp_q.delete();
        end
    endtask

    initial begin : watchdog
        #(20 * 150000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin : main
        // R5: reset state with inputs toggling
        repeat (2) @(posedge bclk);
        for (int i = 0; i < 8; i++) begin
            drive_bit(i[0], ~i[0]);
            @(negedge bclk);
            #2;
            checks++;
            if (lrck_o !== 1'b0 || sdata_o !== 1'b0) begin
                errors++;
                $display("FAIL R5 outputs in reset: actual %b%b expected 00", lrck_o, sdata_o);
            end
        end
        lrck_i = 0;
        sdata_i = 0;

        run_config(1'b1, 16, 8);   // R1, R7
        run_config(1'b0, 16, 8);   // R2, R7, R8
        run_config(1'b1, 24, 8);   // R1, R7, R8
        run_config(1'b0, 24, 8);   // R2, R7, R8

        checks++;
        if (r3_bad != 0) begin
            errors++;
            $display("FAIL R3 output moved at falling edge: actual %0d expected 0", r3_bad);
        end
        checks++;
        if (r6_bad != 0) begin
            errors++;
            $display("FAIL R6 bclk_o mismatch: actual %0d expected 0", r6_bad);
        end

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule